// File: doc/BRIEF.md
# SPI Memory-Mapped Write Window

This block lets a processor send bytes to SPI targets with ordinary memory stores, with no polling per word. The bus address space holds one window per chip select. A store that lands in a window is queued and sent out on the SPI pins on that window's chip select. A 32-bit store leaves as four bytes. A byte store leaves as one byte. The link is transmit-only: it uses 8-bit words, SPI mode 0, and sends the most significant bit first.

Bus stores enter through a valid/ready channel. A store is taken on any clock edge where `wr_valid` and `wr_ready` are both high. The source must hold address, size and data stable while `wr_valid` is high and `wr_ready` is low. `wr_ready` depends only on how much room the internal byte queue has left, never on `wr_valid`. A small control register, written through a plain strobe interface, picks one of two chip-select policies. In hold mode the chip select stays low between stores. In release mode the chip select goes high after every store.

Top module: `spi_dwin_top`

## Requirements
- R1: While reset is held and after it is released, all `spi_cs_n` bits are 1, `spi_sclk` and `spi_mosi` are 0, `wr_ready` is 1 and `err_flag` is 0. After reset the block is in hold mode.
- R2: The target window is `wr_addr[WIN_SHIFT+2:WIN_SHIFT]` (bits 14:12 by default). The bytes of a store go out while only `spi_cs_n[window]` is low.
- R3: A word store (`wr_size`=1) goes out as four bytes, bits 7:0 first and bits 31:24 last. Each byte is sent MSB first. `spi_mosi` is valid at each rising `spi_sclk` edge. `spi_sclk` idles low and has a period of 2*HALF_DIV clocks within a byte.
- R4: A byte store (`wr_size`=0) sends one byte, taken from data lane `wr_addr[1:0]` (lane n is `wr_data[8n+7:8n]`).
- R5: `wr_ready` is high exactly when the 8-entry byte queue has at least 4 free entries. Two word stores accepted back to back right after an idle period leave `wr_ready` low in the following cycle. A stalled store is sent once it is accepted.
- R6: A store to a window whose `win_en` bit is 0 is accepted but sends no bytes. It sets `err_flag` one cycle after acceptance, and `err_flag` stays set until reset.
- R7: A register write with `reg_addr`=0x20 and value 0 selects hold mode. In hold mode chip select stays low across stores to one window and after the queue drains. Register writes at any other offset have no effect.
- R8: A nonzero value written at offset 0x20 selects release mode. In release mode chip select goes high after the last byte of each store. Each time chip select is released, all `spi_cs_n` bits stay high for at least 2*HALF_DIV clocks before any chip select goes low again. Switching to release mode while a chip select is held releases it.
- R9: A store to a different window while a chip select is held first releases the held one. The new one then stays held in hold mode.
- R10: At most one `spi_cs_n` bit is low at any time. `spi_sclk` is low whenever no chip select is low.
- R11: In release mode each store causes exactly one chip-select release, and the bytes of one store are never split by a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus store request valid |
| wr_ready | output | 1 | Queue can take a store (at least 4 bytes free) |
| wr_addr | input | ADDR_W | Store address; window index and byte lane |
| wr_size | input | 1 | 1 = 32-bit store, 0 = byte store |
| wr_data | input | 32 | Store data |
| win_en | input | 8 | Per-window enable |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 6 | Control register byte offset |
| reg_wdata | input | 32 | Control register write data |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI serial data out |
| spi_cs_n | output | 8 | Active-low chip selects, one per window |
| err_flag | output | 1 | Sticky flag: a store hit a disabled window |

## Verification
Each result has a fixed delay after the edge that causes it:
- `err_flag` and `wr_ready` change on the clock edge after the store is accepted.
- A chip select goes low one clock after the sequencer sees a queued byte.
- The first rising `spi_sclk` edge comes HALF_DIV clocks after the chip select goes low.
- A released chip select stays high for 2*HALF_DIV+1 clocks.

The bench samples every output on the falling clock edge, between register updates. It rebuilds each byte from `spi_mosi` at the rising `spi_sclk` edges it sees. It compares each byte with a queue of expected bytes that it fills when each store is accepted. It measures clock periods and release gaps by counting sampled cycles. Checks with a fixed delay, such as `err_flag`, `wr_ready` and the held chip select, are made on the falling edge after the number of edges listed above.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
  // Window count and queue lane geometry shared by every unit
  localparam int unsigned SPIW_NUM_CS = 8;
  localparam int unsigned SPIW_CS_W   = $clog2(SPIW_NUM_CS);
  localparam int unsigned SPIW_LANES  = 4;
  localparam int unsigned SPIW_PUSH_W = $clog2(SPIW_LANES + 1);

  // Byte offset of the chip-select policy register
  localparam logic [5:0] SPIW_POLICY_OFS = 6'h20;

  typedef struct packed {
    logic [SPIW_CS_W-1:0] cs;
    logic                 last;   // final byte of one bus store
    logic [7:0]           data;
  } spiw_entry_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_GAP   = 2'd2
  } spiw_seq_e;
endpackage

// File: rtl/spiw_ingress.sv
module spiw_ingress
  import spiw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_SHIFT = 12
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_valid,
  input  logic                                  wr_ready,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic                                  wr_size,
  input  logic [31:0]                           wr_data,
  input  logic [SPIW_NUM_CS-1:0]                win_en,
  output logic [SPIW_PUSH_W-1:0]                push_n,
  output spiw_entry_t [SPIW_LANES-1:0]          push_lane,
  output logic                                  err_flag
);
  logic [SPIW_CS_W-1:0] win_idx;
  logic                 accept;
  logic                 hit;
  logic                 unused_addr_bits;

  assign win_idx          = wr_addr[WIN_SHIFT +: SPIW_CS_W];
  assign accept           = wr_valid & wr_ready;
  assign hit              = win_en[win_idx];
  assign unused_addr_bits = ^wr_addr;

  always_comb begin
    push_n = '0;
    if (accept && hit) begin
      push_n = wr_size ? SPIW_PUSH_W'(SPIW_LANES) : SPIW_PUSH_W'(1);
    end
  end

  // Word stores fill all lanes little-endian; byte stores use lane 0 only
  always_comb begin
    for (int k = 0; k < SPIW_LANES; k++) begin
      push_lane[k].cs = win_idx;
      if (wr_size) begin
        push_lane[k].data = wr_data[8*k +: 8];
        push_lane[k].last = (k == SPIW_LANES - 1);
      end else begin
        push_lane[k].data = (k == 0) ? wr_data[{wr_addr[1:0], 3'b000} +: 8] : 8'h00;
        push_lane[k].last = (k == 0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
    end else if (accept && !hit) begin
      err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/spiw_byte_fifo.sv
module spiw_byte_fifo
  import spiw_pkg::*;
#(
  parameter  int DEPTH = 8,   // power of two, at least SPIW_LANES
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SPIW_PUSH_W-1:0]       push_n,
  input  spiw_entry_t [SPIW_LANES-1:0] push_lane,
  input  logic                         pop,
  output spiw_entry_t                  head,
  output logic                         empty,
  output logic [CNT_W-1:0]             free_cnt
);
  spiw_entry_t      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt;

  // Several lanes may land in one cycle
  always_ff @(posedge clk) begin
    for (int k = 0; k < SPIW_LANES; k++) begin
      if (k < int'(push_n)) begin
        mem[wr_ptr + PTR_W'(k)] <= push_lane[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      if (pop) begin
        rd_ptr <= rd_ptr + PTR_W'(1);
      end
      cnt <= cnt + CNT_W'(push_n) - CNT_W'(pop);
    end
  end

  assign head     = mem[rd_ptr];
  assign empty    = (cnt == '0);
  assign free_cnt = CNT_W'(DEPTH) - cnt;
endmodule

// File: rtl/spiw_shifter.sv
module spiw_shifter #(
  parameter  int HALF_DIV = 2,
  localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       sclk,
  output logic       mosi_bit,
  output logic       done
);
  logic [7:0]       sreg;
  logic [DIV_W-1:0] div;
  logic [2:0]       bitn;
  logic             busy;

  // Mode 0: data launched on falling edges, sampled by the target on rising
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      div  <= '0;
      bitn <= '0;
      busy <= 1'b0;
      sclk <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sreg <= load_byte;
        div  <= '0;
        bitn <= '0;
        busy <= 1'b1;
        sclk <= 1'b0;
      end else if (busy) begin
        if (div == DIV_W'(HALF_DIV - 1)) begin
          div  <= '0;
          sclk <= ~sclk;
          if (sclk) begin
            sreg <= {sreg[6:0], 1'b0};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          div <= div + DIV_W'(1);
        end
      end
    end
  end

  assign mosi_bit = sreg[7];
endmodule

// File: rtl/spi_dwin_top.sv
module spi_dwin_top
  import spiw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WIN_SHIFT  = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int HALF_DIV   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic                   wr_size,
  input  logic [31:0]            wr_data,
  input  logic [SPIW_NUM_CS-1:0] win_en,
  input  logic                   reg_we,
  input  logic [5:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic                   spi_sclk,
  output logic                   spi_mosi,
  output logic [SPIW_NUM_CS-1:0] spi_cs_n,
  output logic                   err_flag
);
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  logic [SPIW_PUSH_W-1:0]       push_n;
  spiw_entry_t [SPIW_LANES-1:0] push_lane;
  spiw_entry_t                  head;
  logic                         fifo_empty;
  logic [CNT_W-1:0]             fifo_free;
  logic                         pop;
  logic                         rel_now;
  logic                         shift_done;
  logic                         mosi_bit;

  logic                         rel_mode;
  spiw_seq_e                    state;
  logic                         cs_on;
  logic [SPIW_CS_W-1:0]         cs_sel;
  logic                         last_q;
  logic [GAP_W-1:0]             gap_cnt;

  assign wr_ready = (fifo_free >= CNT_W'(SPIW_LANES));

  spiw_ingress #(
    .ADDR_W    (ADDR_W),
    .WIN_SHIFT (WIN_SHIFT)
  ) u_ingress (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_size   (wr_size),
    .wr_data   (wr_data),
    .win_en    (win_en),
    .push_n    (push_n),
    .push_lane (push_lane),
    .err_flag  (err_flag)
  );

  spiw_byte_fifo #(
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (push_n),
    .push_lane (push_lane),
    .pop       (pop),
    .head      (head),
    .empty     (fifo_empty),
    .free_cnt  (fifo_free)
  );

  spiw_shifter #(
    .HALF_DIV (HALF_DIV)
  ) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pop),
    .load_byte (head.data),
    .sclk      (spi_sclk),
    .mosi_bit  (mosi_bit),
    .done      (shift_done)
  );

  // Chip-select policy: zero holds, any nonzero value releases per store
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_mode <= 1'b0;
    end else if (reg_we && reg_addr == SPIW_POLICY_OFS) begin
      rel_mode <= |reg_wdata;
    end
  end

  // Sequencer decisions taken while idle
  always_comb begin
    pop     = 1'b0;
    rel_now = 1'b0;
    if (state == SQ_IDLE) begin
      if (!fifo_empty && (!cs_on || head.cs == cs_sel)) begin
        pop = 1'b1;
      end else if (cs_on && (!fifo_empty || rel_mode)) begin
        rel_now = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cs_on   <= 1'b0;
      cs_sel  <= '0;
      last_q  <= 1'b0;
      gap_cnt <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (pop) begin
            cs_on  <= 1'b1;
            cs_sel <= head.cs;
            last_q <= head.last;
            state  <= SQ_SHIFT;
          end else if (rel_now) begin
            cs_on   <= 1'b0;
            gap_cnt <= '0;
            state   <= SQ_GAP;
          end
        end
        SQ_SHIFT: begin
          if (shift_done) begin
            if (last_q && rel_mode) begin
              cs_on   <= 1'b0;
              gap_cnt <= '0;
              state   <= SQ_GAP;
            end else begin
              state <= SQ_IDLE;
            end
          end
        end
        SQ_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            state <= SQ_IDLE;
          end else begin
            gap_cnt <= gap_cnt + GAP_W'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    spi_cs_n = '1;
    if (cs_on) begin
      spi_cs_n[cs_sel] = 1'b0;
    end
  end

  assign spi_mosi = cs_on & mosi_bit;
endmodule

// File: rtl/spiw_checker.sv
module spiw_checker
  import spiw_pkg::*;
#(
  parameter  int ADDR_W     = 16,
  parameter  int WIN_SHIFT  = 12,
  parameter  int FIFO_DEPTH = 8,
  parameter  int HALF_DIV   = 2,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1),
  localparam int GAP_CYC    = 2 * HALF_DIV,
  localparam int RUN_W      = $clog2(GAP_CYC + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [SPIW_NUM_CS-1:0] win_en,
  input logic                   err_flag,
  input logic                   spi_sclk,
  input logic [SPIW_NUM_CS-1:0] spi_cs_n,
  input logic [SPIW_PUSH_W-1:0] push_n,
  input logic [CNT_W-1:0]       fifo_free
);
  logic [RUN_W-1:0] high_run;

  // Saturating count of cycles with every chip select high
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_run <= RUN_W'(GAP_CYC);
    end else if (&spi_cs_n) begin
      if (high_run != RUN_W'(GAP_CYC)) begin
        high_run <= high_run + RUN_W'(1);
      end
    end else begin
      high_run <= '0;
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != '0) |-> (fifo_free >= CNT_W'(push_n)));

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !win_en[wr_addr[WIN_SHIFT +: SPIW_CS_W]]) |=> err_flag);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_release_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&spi_cs_n) |-> (high_run >= RUN_W'(GAP_CYC)));

  assert_one_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sclk);
endmodule

bind spi_dwin_top spiw_checker #(
  .ADDR_W     (ADDR_W),
  .WIN_SHIFT  (WIN_SHIFT),
  .FIFO_DEPTH (FIFO_DEPTH),
  .HALF_DIV   (HALF_DIV)
) u_spiw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .win_en    (win_en),
  .err_flag  (err_flag),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .push_n    (push_n),
  .fifo_free (fifo_free)
);

// File: tb/tb_spi_dwin_top.sv
module tb_spi_dwin_top;
  localparam int HALF_DIV = 2;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic        wr_size = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  win_en = 8'hFF;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        spi_sclk;
  logic        spi_mosi;
  logic [7:0]  spi_cs_n;
  logic        err_flag;

  always #2 clk = ~clk;

  spi_dwin_top #(.HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .win_en(win_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .err_flag(err_flag)
  );

  int vecs = 0;
  int errs = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference: expected bytes as window*256 + byte, filled at acceptance
  int       exp_q[$];
  logic [7:0] bit_acc = '0;
  int       nbits = 0;
  int       rx_count = 0;
  int       rel_cnt = 0;
  int       high_run = 1000;
  int       cyc = 0;
  int       last_rise = 0;
  int       low_cnt;
  int       cs_idx;
  int       e;
  bit       prev_all_high = 1;
  logic     prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      low_cnt = $countones(~spi_cs_n);
      chk(low_cnt <= 1, "R10 single chip select", low_cnt, 1);
      if (low_cnt == 0) chk(!spi_sclk, "R10 clock idles without select", spi_sclk, 0);
      if (low_cnt != 0 && prev_all_high)
        chk(high_run >= 2*HALF_DIV, "R8 release gap length", high_run, 2*HALF_DIV);
      if (low_cnt == 0 && !prev_all_high) begin
        rel_cnt++;
        chk(nbits == 0, "R11 release inside a byte", nbits, 0);
      end
      high_run = (low_cnt == 0) ? high_run + 1 : 0;
      if (spi_sclk && !prev_sclk) begin
        if (nbits != 0)
          chk(cyc - last_rise == 2*HALF_DIV, "R3 clock period", cyc - last_rise, 2*HALF_DIV);
        last_rise = cyc;
        bit_acc = {bit_acc[6:0], spi_mosi};
        nbits++;
        if (nbits == 8) begin
          cs_idx = -1;
          for (int i = 0; i < 8; i++) if (!spi_cs_n[i]) cs_idx = i;
          if (exp_q.size() == 0) begin
            chk(0, "R2 unexpected byte", cs_idx*256 + bit_acc, 0);
          end else begin
            e = exp_q.pop_front();
            chk(cs_idx*256 + int'(bit_acc) == e, "R2 R3 window and byte", cs_idx*256 + bit_acc, e);
          end
          nbits = 0;
          rx_count++;
        end
      end
      prev_all_high = (low_cnt == 0);
      prev_sclk = spi_sclk;
    end
  end

  task automatic bus_write(input int win, input int low, input bit word,
                           input logic [31:0] d, output int stalls);
    stalls = 0;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 16'((win << 12) | low);
    wr_size  = word;
    wr_data  = d;
    while (!wr_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
    if (win_en[win]) begin
      if (word) begin
        for (int k = 0; k < 4; k++) exp_q.push_back(win*256 + int'(d[8*k +: 8]));
      end else begin
        exp_q.push_back(win*256 + int'(d[8*(low%4) +: 8]));
      end
    end
    #1 wr_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((exp_q.size() != 0 || nbits != 0) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, "R3 all queued bytes sent", exp_q.size(), 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done_flag) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", WD_LIMIT, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int st;
    int rel0;
    int rx0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 8'hFF, "R1 chip selects in reset", spi_cs_n, 8'hFF);
    chk(spi_sclk == 0 && spi_mosi == 0, "R1 clock and data in reset", {spi_sclk, spi_mosi}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1, "R1 ready after reset", wr_ready, 1);
    chk(err_flag == 0, "R1 error clear after reset", err_flag, 0);
    chk(spi_cs_n == 8'hFF, "R1 chip selects after reset", spi_cs_n, 8'hFF);

    // R2 R3 R11: release mode, one word store
    reg_write(6'h20, 32'h1);
    rel0 = rel_cnt;
    bus_write(3, 0, 1'b1, 32'hA1B2_C3D4, st);
    wait_drain();
    chk(rel_cnt - rel0 == 1, "R11 one release per word store", rel_cnt - rel0, 1);
    chk(spi_cs_n == 8'hFF, "R8 released after store", spi_cs_n, 8'hFF);

    // R4 byte stores on each lane
    rel0 = rel_cnt;
    for (int k = 0; k < 4; k++) bus_write(5, k, 1'b0, 32'h4433_2211, st);
    wait_drain();
    chk(rel_cnt - rel0 == 4, "R4 R11 one release per byte store", rel_cnt - rel0, 4);

    // R5 back-pressure
    bus_write(1, 0, 1'b1, 32'h0403_0201, st);
    bus_write(1, 0, 1'b1, 32'h0807_0605, st);
    @(negedge clk);
    chk(wr_ready == 0, "R5 ready drops with 7 bytes queued", wr_ready, 0);
    bus_write(1, 0, 1'b1, 32'h0C0B_0A09, st);
    chk(st > 0, "R5 third store stalled", st, 1);
    wait_drain();

    // R6 disabled window
    win_en = 8'hBF;
    chk(err_flag == 0, "R6 error clear before", err_flag, 0);
    rx0 = rx_count;
    bus_write(6, 0, 1'b1, 32'hDEAD_BEEF, st);
    @(negedge clk);
    chk(err_flag == 1, "R6 error set after disabled store", err_flag, 1);
    repeat (40) @(negedge clk);
    chk(rx_count == rx0, "R6 no bytes from disabled window", rx_count, rx0);
    chk(spi_cs_n == 8'hFF, "R6 no select from disabled window", spi_cs_n, 8'hFF);
    win_en = 8'hFF;
    repeat (5) @(negedge clk);
    chk(err_flag == 1, "R6 error sticky", err_flag, 1);

    // R7 hold mode
    reg_write(6'h20, 32'h0);
    rel0 = rel_cnt;
    bus_write(2, 0, 1'b1, 32'h1122_3344, st);
    bus_write(2, 0, 1'b1, 32'h5566_7788, st);
    bus_write(2, 0, 1'b1, 32'h99AA_BBCC, st);
    wait_drain();
    chk(rel_cnt - rel0 == 0, "R7 no release in hold mode", rel_cnt - rel0, 0);
    chk(spi_cs_n == 8'hFB, "R7 select held after drain", spi_cs_n, 8'hFB);
    reg_write(6'h24, 32'h1);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 8'hFB, "R7 other offset ignored", spi_cs_n, 8'hFB);

    // R9 window switch while held
    rel0 = rel_cnt;
    bus_write(4, 0, 1'b1, 32'hF00D_CAFE, st);
    wait_drain();
    chk(rel_cnt - rel0 == 1, "R9 old select released on switch", rel_cnt - rel0, 1);
    chk(spi_cs_n == 8'hEF, "R9 new select held", spi_cs_n, 8'hEF);

    // R8 switching to release mode frees the held select
    rel0 = rel_cnt;
    reg_write(6'h20, 32'h5);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 8'hFF, "R8 policy change releases select", spi_cs_n, 8'hFF);
    chk(rel_cnt - rel0 == 1, "R8 one release on policy change", rel_cnt - rel0, 1);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule